// File: doc/BRIEF.md
# Plotter Step Command Port with SPI Forwarding

This block is the host-facing port of an incremental pen plotter. A processor writes one 6-bit motion command per step. Each command is a pen lift, a pen drop, or a single step in X and/or Y. The block stores the command and widens it to a byte with zero padding. It then shifts the byte out as an SPI mode-0 master to a downstream controller, which does the real plotting.

When chip select is released after the eighth bit, the port raises a completion interrupt. The interrupt is a level and stays high until the host acknowledges it or issues the next command. A status read reports four flags: busy, not ready, a sticky error flag and the pending interrupt. The not-ready flag follows an external ready pin through a two-flop synchroniser. The port refuses commands while the device is not ready, or while the previous byte is still in flight.

Top module: `plotter_step_port`

## Requirements
- R1: The command field is 6 bits: bit 5 lifts the pen, bit 4 lowers it, bit 3 steps +X, bit 2 steps -X, bit 1 steps +Y, bit 0 steps -Y. The byte sent is {2'b00, command}.
- R2: A write accepted while idle and ready sets busy. A status read issued on the following cycle returns busy = 1.
- R3: Each accepted command produces exactly one chip-select low period. That period carries 8 bits, most significant first, in SPI mode 0: the clock idles low, data is stable at the rising edge, and the clock never runs while chip select is high.
- R4: Busy clears on the same clock edge that raises chip select after the last bit. The interrupt rises on that same edge.
- R5: The interrupt is a level. It stays high until a one-cycle `irq_ack` pulse clears it.
- R6: An accepted write clears a pending interrupt.
- R7: A write that arrives while busy has no effect on the frame in flight and starts no frame of its own. It sets the sticky error flag.
- R8: The status byte appears on `rd_data` the cycle after `rd_en`, with bit 0 busy, bit 1 not ready, bit 2 error, bit 3 interrupt, and bits 7:4 zero. A read returns the error flag and then clears it.
- R9: `dev_ready` passes through two synchronising flops, and not ready is its inverse. While not ready, a write starts no frame, does not set busy and does not set the error flag.
- R10: After reset, chip select is high, the SPI clock is low, the interrupt is low, and, once the ready pin has been synchronised, the status reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command write strobe |
| wr_cmd | input | 6 | Motion command (R1 layout) |
| rd_en | input | 1 | Status read strobe |
| rd_data | output | 8 | Registered status byte |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Command-complete interrupt level |
| dev_ready | input | 1 | Asynchronous downstream ready |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
The hardest case to reach is a second write that lands while a byte is already on the wire. The bench issues two writes on consecutive cycles. It then checks that the captured frame carries only the first command and that the frame count rose by one. It also checks that the error flag shows on exactly one read. A second hard case is a command that lands during the not-ready window. To reach it, the bench drops the ready pin, waits past the synchroniser, writes, and confirms that no chip-select activity follows. Randomised commands with random gaps then exercise every bit pattern through the padding.

// File: rtl/plt_pkg.sv
package plt_pkg;
    localparam int CMD_W  = 6;
    localparam int BYTE_W = 8;
    localparam int PAD_W  = BYTE_W - CMD_W;

    typedef struct packed {
        logic pen_up;
        logic pen_down;
        logic x_pos;
        logic x_neg;
        logic y_pos;
        logic y_neg;
    } plt_cmd_t;

    typedef enum logic [1:0] {
        SPI_IDLE,
        SPI_LOW,
        SPI_HIGH,
        SPI_HOLD
    } spi_state_e;

    typedef struct packed {
        logic [3:0] rsvd;
        logic       irq;
        logic       err;
        logic       not_ready;
        logic       busy;
    } plt_status_t;

    function automatic logic [BYTE_W-1:0] pad_cmd(plt_cmd_t c);
        return {{PAD_W{1'b0}}, c};
    endfunction
endpackage

// File: rtl/plt_sync.sv
module plt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/plt_spi_tx.sv
module plt_spi_tx
    import plt_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int DATA_W  = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] data_in,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              done,
    output logic              active
);
    localparam int DIV_W = $clog2(CLK_DIV + 1);
    localparam int IDX_W = $clog2(DATA_W);

    spi_state_e        state;
    logic [DATA_W-1:0] shreg;
    logic [DIV_W-1:0]  div_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic              div_end;

    assign div_end = (div_cnt == DIV_W'(CLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SPI_IDLE;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            shreg   <= '0;
            div_cnt <= '0;
            bit_idx <= '0;
        end else begin
            case (state)
                SPI_IDLE: begin
                    if (start) begin
                        shreg   <= data_in;
                        cs_n    <= 1'b0;
                        div_cnt <= '0;
                        bit_idx <= '0;
                        state   <= SPI_LOW;
                    end
                end
                SPI_LOW: begin
                    if (div_end) begin
                        div_cnt <= '0;
                        sclk    <= 1'b1;
                        state   <= SPI_HIGH;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                SPI_HIGH: begin
                    if (div_end) begin
                        div_cnt <= '0;
                        sclk    <= 1'b0;
                        if (bit_idx == IDX_W'(DATA_W - 1)) begin
                            state <= SPI_HOLD;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            shreg   <= {shreg[DATA_W-2:0], 1'b0};
                            state   <= SPI_LOW;
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                SPI_HOLD: begin
                    if (div_end) begin
                        div_cnt <= '0;
                        cs_n    <= 1'b1;
                        state   <= SPI_IDLE;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: state <= SPI_IDLE;
            endcase
        end
    end

    assign mosi   = shreg[DATA_W-1];
    assign done   = (state == SPI_HOLD) && div_end;
    assign active = (state != SPI_IDLE);
endmodule

// File: rtl/plt_ctrl.sv
module plt_ctrl
    import plt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  plt_cmd_t          wr_cmd,
    input  logic              rd_en,
    input  logic              irq_ack,
    input  logic              not_ready,
    input  logic              tx_done,
    output logic              tx_start,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              busy,
    output logic              irq,
    output logic              err,
    output logic [BYTE_W-1:0] rd_data
);
    plt_cmd_t    cmd_q;
    logic        start_q;
    logic        accept;
    plt_status_t status;

    assign accept = wr_en && !busy && !not_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            start_q <= 1'b0;
            busy    <= 1'b0;
            irq     <= 1'b0;
            err     <= 1'b0;
            rd_data <= '0;
        end else begin
            start_q <= accept;
            if (accept) cmd_q <= wr_cmd;

            if (accept)       busy <= 1'b1;
            else if (tx_done) busy <= 1'b0;

            if (tx_done)                irq <= 1'b1;
            else if (accept || irq_ack) irq <= 1'b0;

            if (wr_en && busy) err <= 1'b1;
            else if (rd_en)    err <= 1'b0;

            if (rd_en) rd_data <= status;
        end
    end

    always_comb begin
        status           = '0;
        status.busy      = busy;
        status.not_ready = not_ready;
        status.err       = err;
        status.irq       = irq;
    end

    assign tx_start = start_q;
    assign tx_byte  = pad_cmd(cmd_q);
endmodule

// File: rtl/plotter_step_port.sv
module plotter_step_port
    import plt_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CMD_W-1:0]  wr_cmd,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              irq_ack,
    output logic              irq,
    input  logic              dev_ready,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n
);
    logic              ready_s;
    logic              not_ready;
    logic              tx_start;
    logic              tx_done;
    logic              tx_active;
    logic [BYTE_W-1:0] tx_byte;
    logic              busy;
    logic              err_flag;

    plt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (dev_ready),
        .q   (ready_s)
    );

    assign not_ready = !ready_s;

    plt_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_cmd    (plt_cmd_t'(wr_cmd)),
        .rd_en     (rd_en),
        .irq_ack   (irq_ack),
        .not_ready (not_ready),
        .tx_done   (tx_done),
        .tx_start  (tx_start),
        .tx_byte   (tx_byte),
        .busy      (busy),
        .irq       (irq),
        .err       (err_flag),
        .rd_data   (rd_data)
    );

    plt_spi_tx #(.CLK_DIV(CLK_DIV), .DATA_W(BYTE_W)) tx_i (
        .clk     (clk),
        .rst     (rst),
        .start   (tx_start),
        .data_in (tx_byte),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n),
        .done    (tx_done),
        .active  (tx_active)
    );
endmodule

// File: rtl/plotter_step_port_chk.sv
module plotter_step_port_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic irq_ack,
    input logic irq,
    input logic busy,
    input logic not_ready,
    input logic err_flag,
    input logic tx_active,
    input logic spi_sclk,
    input logic spi_cs_n
);
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    p_busy_on_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && !not_ready) |=> busy);

    p_release_done_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> (irq && !busy));

    p_engine_busy_r4: assert property (@(posedge clk) disable iff (rst)
        tx_active |-> busy);

    p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack && !wr_en) |=> irq);

    p_irq_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && !not_ready) |=> !irq);

    p_busy_write_err_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> err_flag);

    p_refuse_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && not_ready && !busy) |=> !busy);
endmodule

bind plotter_step_port plotter_step_port_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .irq_ack   (irq_ack),
    .irq       (irq),
    .busy      (busy),
    .not_ready (not_ready),
    .err_flag  (err_flag),
    .tx_active (tx_active),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n)
);

// File: tb/plotter_step_port_tb_top.sv
`timescale 1ns/1ps
module plotter_step_port_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [5:0] wr_cmd = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic       dev_ready = 1'b1;
    logic       spi_sclk, spi_mosi, spi_cs_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    plotter_step_port #(.CLK_DIV(2), .SYNC_STAGES(2)) dut_i (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_cmd (wr_cmd),
        .rd_en (rd_en), .rd_data (rd_data), .irq_ack (irq_ack), .irq (irq),
        .dev_ready (dev_ready), .spi_sclk (spi_sclk), .spi_mosi (spi_mosi),
        .spi_cs_n (spi_cs_n)
    );

    // SPI capture on the wire
    logic       mon_en = 1'b0;
    logic       in_frame = 1'b0;
    logic [7:0] cap = '0;
    int         cap_bits = 0;
    int         frames = 0;
    logic [7:0] last_byte = '0;
    int         last_bits = 0;
    int         mode_err = 0;

    always @(negedge spi_cs_n) if (mon_en) begin
        in_frame = 1'b1; cap = '0; cap_bits = 0;
        if (spi_sclk) mode_err++;
    end
    always @(posedge spi_sclk) if (mon_en) begin
        if (in_frame) begin cap = {cap[6:0], spi_mosi}; cap_bits++; end
        else mode_err++;
    end
    always @(posedge spi_cs_n) if (mon_en && in_frame) begin
        in_frame = 1'b0; frames++; last_byte = cap; last_bits = cap_bits;
    end

    function automatic logic [7:0] exp_byte(logic [5:0] c);
        return {2'b00, c};
    endfunction

    function automatic logic [7:0] exp_status(logic b, logic nr, logic e, logic i);
        return {4'b0000, i, e, nr, b};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] c);
        @(negedge clk); wr_en = 1'b1; wr_cmd = c;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic read_status(output logic [7:0] s);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; s = rd_data;
    endtask

    task automatic do_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic wait_irq(input string tag);
        int k;
        k = 0;
        while (!irq && k < 300) begin @(negedge clk); k++; end
        check(irq == 1'b1, {tag, " interrupt arrival"}, irq, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] st;
        int f0;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mon_en = 1'b1;
        repeat (4) @(negedge clk);

        // R10 reset state
        check(spi_cs_n == 1'b1, "R10 cs_n", spi_cs_n, 1);
        check(spi_sclk == 1'b0, "R10 sclk", spi_sclk, 0);
        check(irq == 1'b0, "R10 irq", irq, 0);
        read_status(st);
        check(st == 8'h00, "R10 status", st, 0);

        // R1 R2 R3 R4: basic command
        f0 = frames;
        do_write(6'b001010);
        read_status(st);
        check(st == exp_status(1, 0, 0, 0), "R2 busy after write", st, exp_status(1, 0, 0, 0));
        wait_irq("R4");
        check(spi_cs_n == 1'b1, "R4 cs released with irq", spi_cs_n, 1);
        check(last_byte == exp_byte(6'b001010), "R1 padded byte", last_byte, exp_byte(6'b001010));
        check(last_bits == 8, "R3 bits per frame", last_bits, 8);
        check(frames == f0 + 1, "R3 one frame", frames - f0, 1);
        read_status(st);
        check(st == exp_status(0, 0, 0, 1), "R4 busy clear irq set", st, exp_status(0, 0, 0, 1));

        // R5 irq holds until ack
        repeat (10) @(negedge clk);
        check(irq == 1'b1, "R5 irq held", irq, 1);
        do_ack();
        check(irq == 1'b0, "R5 irq cleared by ack", irq, 0);

        // R6 new write clears pending irq
        do_write(6'b100000);
        wait_irq("R6");
        do_write(6'b010000);
        check(irq == 1'b0, "R6 write clears irq", irq, 0);
        wait_irq("R6");
        check(last_byte == 8'h10, "R1 pen down byte", last_byte, 8'h10);
        do_ack();

        // R7 write while busy ignored, R8 error read-clear
        f0 = frames;
        @(negedge clk); wr_en = 1'b1; wr_cmd = 6'b000101;
        @(negedge clk); wr_cmd = 6'b111111;
        @(negedge clk); wr_en = 1'b0;
        wait_irq("R7");
        check(frames == f0 + 1, "R7 single frame", frames - f0, 1);
        check(last_byte == 8'h05, "R7 first command kept", last_byte, 8'h05);
        read_status(st);
        check(st == exp_status(0, 0, 1, 1), "R8 err reported", st, exp_status(0, 0, 1, 1));
        read_status(st);
        check(st == exp_status(0, 0, 0, 1), "R8 err cleared by read", st, exp_status(0, 0, 0, 1));
        do_ack();

        // R9 not ready refuses writes
        dev_ready = 1'b0;
        repeat (4) @(negedge clk);
        read_status(st);
        check(st == exp_status(0, 1, 0, 0), "R9 not ready flag", st, exp_status(0, 1, 0, 0));
        f0 = frames;
        do_write(6'b000011);
        repeat (60) @(negedge clk);
        check(frames == f0, "R9 no frame when not ready", frames - f0, 0);
        check(spi_cs_n == 1'b1, "R9 cs idle", spi_cs_n, 1);
        read_status(st);
        check(st == exp_status(0, 1, 0, 0), "R9 no busy no err", st, exp_status(0, 1, 0, 0));
        dev_ready = 1'b1;
        repeat (4) @(negedge clk);
        read_status(st);
        check(st == 8'h00, "R9 ready again", st, 0);

        // random commands, R1 R3
        for (int i = 0; i < 24; i++) begin
            logic [5:0] c;
            c = 6'($urandom % 64);
            f0 = frames;
            do_write(c);
            wait_irq("R3 random");
            check(last_byte == exp_byte(c), "R1 random byte", last_byte, exp_byte(c));
            check(frames == f0 + 1 && last_bits == 8, "R3 random frame", last_bits, 8);
            do_ack();
            repeat ($urandom % 4) @(negedge clk);
        end

        check(mode_err == 0, "R3 mode 0 clock idle", mode_err, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule